// File: doc/BRIEF.md
# Fractional Modulus Accumulator

This block sets the fractional part of a fractional-N frequency divider. A main divider signals the end of each of its cycles with a one-clock strobe. On every strobe the block adds a programmed fractional increment to a residue register. The residue wraps modulo Q, and Q is picked by one select bit: 8 or 5. When an addition reaches or passes Q, the residue wraps and the block raises a registered request. That request tells the prescaler control to use its alternate ratio, one count longer, for the divider cycle that follows.

Over Q divider cycles with a fixed increment NF, exactly NF cycles are stretched. The mean division is therefore N + NF/Q. The residue itself is driven out on a port. Downstream logic can use it to cancel the phase ripple, which grows with the residue. The compensation DAC and the charge pump are handled elsewhere.

Top module: `frac_mod_acc`

## Requirements
- R1: The modulus Q is 8 while `mod_sel` is 1 and 5 while it is 0. After any strobe, `acc_val` is less than the Q in force at that strobe.
- R2: On a clock edge with `cyc_done` high, suppose the residue plus the increment is below Q. Then `acc_val` becomes that sum after the edge.
- R3: On a strobe where the residue plus the increment is Q or more, `acc_val` becomes the sum minus Q.
- R4: On an edge with `cyc_done` low, `acc_val` and `alt_req` keep their values.
- R5: `alt_req` is registered. On each strobe it takes the value 1 if that strobe wrapped and 0 if it did not. It keeps that value until the next strobe, so it stays high across back-to-back wrapping strobes.
- R6: An increment of Q or more is treated as Q-1.
- R7: A stored residue above Q-1 is treated as Q-1 before the addition. This case arises after a switch from Q=8 to Q=5.
- R8: A synchronous `rst` clears `acc_val` to 0 and `alt_req` to 0. Reset wins over a strobe in the same cycle.
- R9: Start from a residue of 0 and apply Q strobes with a fixed increment NF below Q. Exactly NF of those strobes raise `alt_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cyc_done | input | 1 | Main divider cycle complete, one clock per event |
| frac_inc | input | INC_W (4) | Fractional increment NF |
| mod_sel | input | 1 | Modulus select: 1 gives Q=8, 0 gives Q=5 |
| alt_req | output | 1 | Request for the alternate prescaler ratio for one divider cycle |
| acc_val | output | ACC_W (3) | Current residue, for ripple compensation |

## Verification
Two events can fall on the same strobe. The first is the wrap of the residue together with a change of modulus. To provoke it, the residue is driven to 7 under Q=8, then the next strobe is issued with `mod_sel` at 0. The residue must be clamped to 4 before the add, and the expected residue and request come from a bench model that works only from R3 and R7. The second case is a strobe that coincides with reset: the outputs must read zero on the next cycle, and no stale request may survive.

// File: rtl/frac_acc_pkg.sv
package frac_acc_pkg;

  // modulus chosen by the select bit
  function automatic int unsigned pick_modulus(logic sel, int unsigned q_hi, int unsigned q_lo);
    return sel ? q_hi : q_lo;
  endfunction

  // limit a value to the range 0 .. q-1
  function automatic int unsigned limit_below(int unsigned v, int unsigned q);
    return (v >= q) ? q - 1 : v;
  endfunction

  // does the sum reach the modulus
  function automatic logic wraps(int unsigned a, int unsigned inc, int unsigned q);
    return (a + inc) >= q;
  endfunction

  // residue after one step, modulo q
  function automatic int unsigned fold(int unsigned a, int unsigned inc, int unsigned q);
    int unsigned s;
    s = a + inc;
    return (s >= q) ? s - q : s;
  endfunction

endpackage

// File: rtl/frac_modsel.sv
module frac_modsel
  import frac_acc_pkg::*;
#(
  parameter int unsigned Q_HI  = 8,
  parameter int unsigned Q_LO  = 5,
  parameter int unsigned INC_W = 4,
  parameter int unsigned ACC_W = 3,
  parameter int unsigned QW    = 4
) (
  input  logic             mod_sel,
  input  logic [INC_W-1:0] frac_inc,
  output logic [QW-1:0]    q_cur,
  output logic [ACC_W-1:0] inc_eff
);
  int unsigned q_int;

  always_comb begin
    q_int   = pick_modulus(mod_sel, Q_HI, Q_LO);
    q_cur   = QW'(q_int);
    // R6: increment saturated to Q-1
    inc_eff = ACC_W'(limit_below(32'(frac_inc), q_int));
  end
endmodule

// File: rtl/frac_adder.sv
module frac_adder
  import frac_acc_pkg::*;
#(
  parameter int unsigned ACC_W = 3,
  parameter int unsigned QW    = 4
) (
  input  logic [ACC_W-1:0] acc_q,
  input  logic [ACC_W-1:0] inc_eff,
  input  logic [QW-1:0]    q_cur,
  output logic [ACC_W-1:0] acc_nxt,
  output logic             ovf
);
  int unsigned acc_eff;

  always_comb begin
    // R7: a residue left over from a larger modulus is clamped
    acc_eff = limit_below(32'(acc_q), 32'(q_cur));
    ovf     = wraps(acc_eff, 32'(inc_eff), 32'(q_cur));
    acc_nxt = ACC_W'(fold(acc_eff, 32'(inc_eff), 32'(q_cur)));
  end
endmodule

// File: rtl/frac_state.sv
module frac_state #(
  parameter int unsigned ACC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [ACC_W-1:0] acc_nxt,
  input  logic             ovf,
  output logic [ACC_W-1:0] acc_q,
  output logic             req_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      req_q <= 1'b0;
    end else if (step) begin
      acc_q <= acc_nxt;
      req_q <= ovf;
    end
  end
endmodule

// File: rtl/frac_mod_acc.sv
module frac_mod_acc #(
  parameter int unsigned Q_HI  = 8,
  parameter int unsigned Q_LO  = 5,
  parameter int unsigned INC_W = 4,
  localparam int unsigned QMAX  = (Q_HI > Q_LO) ? Q_HI : Q_LO,
  localparam int unsigned ACC_W = $clog2(QMAX),
  localparam int unsigned QW    = ACC_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_done,
  input  logic [INC_W-1:0] frac_inc,
  input  logic             mod_sel,
  output logic             alt_req,
  output logic [ACC_W-1:0] acc_val
);
  logic [QW-1:0]    q_cur;
  logic [ACC_W-1:0] inc_eff;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_nxt;
  logic             ovf;
  logic             req_q;
  logic             step_ovf;   // named event: a strobe that wraps

  frac_modsel #(
    .Q_HI(Q_HI), .Q_LO(Q_LO), .INC_W(INC_W), .ACC_W(ACC_W), .QW(QW)
  ) u_modsel (
    .mod_sel (mod_sel),
    .frac_inc(frac_inc),
    .q_cur   (q_cur),
    .inc_eff (inc_eff)
  );

  frac_adder #(.ACC_W(ACC_W), .QW(QW)) u_adder (
    .acc_q  (acc_q),
    .inc_eff(inc_eff),
    .q_cur  (q_cur),
    .acc_nxt(acc_nxt),
    .ovf    (ovf)
  );

  frac_state #(.ACC_W(ACC_W)) u_state (
    .clk    (clk),
    .rst    (rst),
    .step   (cyc_done),
    .acc_nxt(acc_nxt),
    .ovf    (ovf),
    .acc_q  (acc_q),
    .req_q  (req_q)
  );

  assign step_ovf = cyc_done & ovf;
  assign alt_req  = req_q;
  assign acc_val  = acc_q;
endmodule

// File: rtl/frac_mod_acc_chk.sv
module frac_mod_acc_chk #(
  parameter int unsigned ACC_W = 3,
  parameter int unsigned QW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_done,
  input logic             alt_req,
  input logic [ACC_W-1:0] acc_val,
  input logic [QW-1:0]    q_cur,
  input logic             step_ovf
);
  // R1: residue below the modulus of the last strobe
  a_r1_below_modulus: assert property (@(posedge clk) disable iff (rst)
    $past(cyc_done) |-> ({1'b0, acc_val} < $past(q_cur)));

  // R3: a wrapping strobe lowers the residue
  a_r3_overflow_drops: assert property (@(posedge clk) disable iff (rst)
    (cyc_done && step_ovf) |=> (acc_val < $past(acc_val)));

  // R2: a non-wrapping strobe from an in-range residue never lowers it
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (cyc_done && !step_ovf && ({1'b0, acc_val} < q_cur)) |=> (acc_val >= $past(acc_val)));

  // R4: no strobe, no change
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !cyc_done |=> ($stable(acc_val) && $stable(alt_req)));

  // R5: request follows the wrap of the strobe before it
  a_r5_req_follows: assert property (@(posedge clk) disable iff (rst)
    cyc_done |=> (alt_req == $past(step_ovf)));

  // R8: reset clears both outputs
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (acc_val == '0 && !alt_req));
endmodule

bind frac_mod_acc frac_mod_acc_chk #(.ACC_W(ACC_W), .QW(QW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cyc_done(cyc_done),
  .alt_req (alt_req),
  .acc_val (acc_val),
  .q_cur   (q_cur),
  .step_ovf(step_ovf)
);

// File: tb/frac_mod_acc_test.sv
module frac_mod_acc_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_done = 1'b0;
  logic [3:0] frac_inc = '0;
  logic       mod_sel = 1'b0;
  logic       alt_req;
  logic [2:0] acc_val;

  int checks = 0;
  int errors = 0;
  int seen_req = 0;
  logic took = 1'b0;
  int m_acc = 0;

  typedef struct { int acc; logic req; int rq; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;   // 125 MHz

  frac_mod_acc uut (
    .clk(clk), .rst(rst), .cyc_done(cyc_done), .frac_inc(frac_inc),
    .mod_sel(mod_sel), .alt_req(alt_req), .acc_val(acc_val)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: model from the requirements, push, strobe
  task automatic step(int nf, logic sel, int rq);
    int q, eff, n, t;
    exp_t e;
    @(negedge clk);
    q   = sel ? 8 : 5;                    // R1
    eff = (m_acc > q - 1) ? q - 1 : m_acc; // R7
    n   = (nf > q - 1) ? q - 1 : nf;       // R6
    t   = eff + n;
    e.req = (t > q - 1);
    m_acc = e.req ? t - q : t;             // R2 / R3
    e.acc = m_acc;
    e.rq  = rq;
    sb.push_back(e);
    frac_inc = 4'(nf);
    mod_sel  = sel;
    cyc_done = 1'b1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc_done = 1'b0;
    end
  endtask

  always @(posedge clk) took <= cyc_done && !rst;

  // monitor
  always @(negedge clk) begin
    if (took) begin
      exp_t e;
      e = sb.pop_front();
      if (alt_req) seen_req++;
      check($sformatf("R%0d acc", e.rq), int'(acc_val), e.acc);
      check($sformatf("R%0d req", e.rq), int'(alt_req), int'(e.req));
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R8 reset acc", int'(acc_val), 0);
    check("R8 reset req", int'(alt_req), 0);

    // R9 / R1: Q=8, NF=3, eight back-to-back strobes, three wraps
    seen_req = 0;
    for (int i = 0; i < 8; i++) step(3, 1'b1, 9);
    idle(1);
    @(negedge clk);
    check("R9 wrap count", seen_req, 3);

    // R4: idle keeps residue 0 and the raised request
    idle(4);
    check("R4 hold acc", int'(acc_val), 0);
    check("R4 hold req", int'(alt_req), 1);

    // R2 / R3 / R5: Q=5, NF=2
    for (int i = 0; i < 5; i++) step(2, 1'b0, 3);
    idle(2);

    // R5: NF=Q-1 wraps on consecutive strobes
    for (int i = 0; i < 4; i++) step(4, 1'b0, 5);
    idle(2);

    // R6: NF=7 under Q=5 acts as 4
    for (int i = 0; i < 3; i++) step(7, 1'b0, 6);
    idle(2);

    // R7: drive residue to 7 under Q=8, then shrink the modulus
    step(0, 1'b1, 1);
    step(7 - m_acc, 1'b1, 2);
    step(0, 1'b0, 7);
    step(1, 1'b0, 7);
    idle(2);

    // R8: reset together with a strobe
    step(3, 1'b1, 2);
    idle(1);
    @(negedge clk);
    rst = 1'b1;
    cyc_done = 1'b1;
    frac_inc = 4'd5;
    @(negedge clk);
    rst = 1'b0;
    cyc_done = 1'b0;
    m_acc = 0;
    check("R8 reset with strobe acc", int'(acc_val), 0);
    check("R8 reset with strobe req", int'(alt_req), 0);

    // after reset, model and design agree again
    step(6, 1'b1, 2);
    idle(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule